// File: doc/BRIEF.md
# Timer Compare and Capture Unit

A 16-bit timer/counter for a peripheral subsystem. A prescaler derived from the system clock produces count ticks. Several waveform modes shape how the count moves: a free-running up count, clear-on-compare, fast PWM and an up/down phase-correct PWM. Two compare channels each own an output pin and a 2-bit action code. An input capture path latches the running count on a chosen edge of a synchronised input pin. Status flags record overflow, each compare match and each capture. Software clears a flag by writing a 1 to its bit.

Software uses a simple register port with a write strobe, an address, write data and combinational read data. Through this port it sets the clock select, the mode, the compare values, the pin actions and the capture edge. It can also load the count and the capture register. Writing the control register restarts the timer only when the clock select or the mode actually changes. This lets software change the capture edge or a pin action without disturbing a running count.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset every register reads 0, and the compare pins and all flags are low.
- R2: Clock select (CTRL[2:0], address 0) equal to 0 freezes the count. A value n from 1 to 7 advances the count once every 2^(n-1) system clocks, counted from the control write that set it.
- R3: In normal mode (CTRL[5:3]=0) the count runs up to 0xFFFF and wraps to 0. The wrap sets the overflow flag (FLAGS bit 0, address 4). A write to address 5 loads the count.
- R4: In clear-on-compare mode (mode 1) the count returns to 0 on the tick after it equals compare A (address 1). That match sets compare flag A (FLAGS bit 1).
- R5: In fast PWM mode (mode 2) the count wraps at 0xFFFF. At that wrap, a channel with the clear action is driven high and a channel with the set action is driven low. A compare match that comes later applies the channel's action.
- R6: In phase-correct mode with TOP = compare A (mode 3), the count rises to TOP, then falls to 0, then rises again. The overflow flag is set when the count turns at 0.
- R7: Pin action codes are: 0 disconnected (pin reads 0), 1 toggle on match, 2 clear on match, 3 set on match. Channel A uses CTRL[7:6] and pin 0. Channel B uses CTRL[9:8], compare B at address 2, and pin 1. A toggle channel is unchanged at overflow.
- R8: The capture input passes through two synchroniser flops. With CTRL[10]=0 a falling edge is captured; with CTRL[10]=1 a rising edge is captured. On capture, the count present two clocks after the input change is copied to the capture register (address 3), and FLAGS bit 3 is set on the third clock. An edge of the other polarity is ignored.
- R9: In phase-correct mode with TOP = capture register (mode 4), input edges neither load the capture register nor set its flag.
- R10: Writing 1 to a FLAGS bit clears it and writing 0 leaves it. A hardware event in the same cycle wins over the clear.
- R11: A control write that keeps the clock select and mode unchanged leaves the count running. A write that changes either one sets the count to 0 and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_pin | output | 2 | Compare output pins, channel A in bit 0 |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 2 | Compare match flags, channel A in bit 0 |
| capt_flag | output | 1 | Capture flag |

## Verification
The assertions check five rules on every cycle. A frozen clock select holds the count. Clear-on-compare returns to zero after its match. A restart zeroes the count. Capture stays silent in the capture-as-TOP mode. A set flag persists unless a write clears it, and a hardware event always sets its flag. The bench scenarios cover what needs a known history: prescale rates, the phase-correct turn points, the order of the overflow and match pin actions, the capture latency and captured value, and the difference between control writes that restart the timer and ones that do not.

// File: rtl/cct_pkg.sv
package cct_pkg;
  parameter int CNT_W = 16;
  parameter int CS_W  = 3;
  parameter int MODE_W = 3;
  parameter int NCH   = 2;
  parameter int NFLAG = 2 + NCH;
  localparam int PRE_W = (1 << CS_W) - 2;

  localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CTC    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_FAST   = 3'd2;
  localparam logic [MODE_W-1:0] MODE_PC_A   = 3'd3;
  localparam logic [MODE_W-1:0] MODE_PC_I   = 3'd4;

  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_TOG = 2'd1,
    ACT_CLR = 2'd2,
    ACT_SET = 2'd3
  } act_e;

  // prescale mask: tick when low (n-1) prescaler bits are all ones
  function automatic logic [PRE_W-1:0] presc_mask(input logic [CS_W-1:0] cs);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(cs) - 1);
    return m;
  endfunction

  function automatic logic pin_on_match(input act_e a, input logic cur);
    case (a)
      ACT_TOG: return ~cur;
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      default: return cur;
    endcase
  endfunction

  // inverse of the match action; toggle and off leave the pin
  function automatic logic pin_on_ovf(input act_e a, input logic cur);
    case (a)
      ACT_CLR: return 1'b1;
      ACT_SET: return 1'b0;
      default: return cur;
    endcase
  endfunction

  function automatic logic is_pwm(input logic [MODE_W-1:0] m);
    return (m == MODE_FAST) || (m == MODE_PC_A) || (m == MODE_PC_I);
  endfunction
endpackage

// File: rtl/cct_presc.sv
module cct_presc
  import cct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [CS_W-1:0] cs,
  output logic            tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = presc_mask(cs);
  assign tick = (cs != '0) && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else if (cs != '0)     pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/cct_count.sv
module cct_count
  import cct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  top_a,
  input  logic [CNT_W-1:0]  top_i,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_evt
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic             down_q, down_d;
  logic [CNT_W-1:0] cnt_d, top;

  assign top = (mode == MODE_PC_I) ? top_i : top_a;

  always_comb begin
    cnt_d   = cnt;
    down_d  = down_q;
    ovf_evt = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      case (mode)
        MODE_CTC: begin
          cnt_d   = (cnt == top_a) ? '0 : cnt + CNT_W'(1);
          ovf_evt = (cnt == CMAX);
        end
        MODE_PC_A, MODE_PC_I: begin
          if (!down_q) begin
            if (cnt >= top) begin
              down_d = 1'b1;
              cnt_d  = (cnt == '0) ? '0 : cnt - CNT_W'(1);
            end else begin
              cnt_d = cnt + CNT_W'(1);
            end
          end else if (cnt == '0) begin
            down_d  = 1'b0;
            cnt_d   = (top == '0) ? '0 : CNT_W'(1);
            ovf_evt = 1'b1;
          end else begin
            cnt_d = cnt - CNT_W'(1);
          end
        end
        default: begin
          cnt_d   = cnt + CNT_W'(1);
          ovf_evt = (cnt == CMAX);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      down_q <= down_d;
    end
  end
endmodule

// File: rtl/cct_chan.sv
module cct_chan
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  act_e             act,
  input  logic             ovf_evt,
  input  logic             pwm,
  output logic             match_evt,
  output logic             pin
);
  logic pin_q, pin_mid, pin_d;

  assign match_evt = tick && (cnt == cmp);

  always_comb begin
    pin_mid = (ovf_evt && pwm) ? pin_on_ovf(act, pin_q) : pin_q;
    pin_d   = match_evt ? pin_on_match(act, pin_mid) : pin_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = (act == ACT_OFF) ? 1'b0 : pin_q;
endmodule

// File: rtl/cct_capt.sv
module cct_capt
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             rise_sel,
  input  logic             block,
  input  logic [CNT_W-1:0] cnt,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] capt,
  output logic             capt_evt
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  assign rise     = s2_q & ~s3_q;
  assign fall     = ~s2_q & s3_q;
  assign capt_evt = (rise_sel ? rise : fall) && !block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
      capt <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (capt_evt)  capt <= cnt;
      else if (load) capt <= load_val;
    end
  end
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cap_in,
  output logic [NCH-1:0]   cmp_pin,
  output logic             ovf_flag,
  output logic [NCH-1:0]   cmp_flag,
  output logic             capt_flag
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2,
                         A_CAPT = 3'd3, A_FLAG = 3'd4, A_CNT  = 3'd5;
  localparam int CTRL_W = CS_W + MODE_W + 2 * NCH + 1;
  localparam int ACT_LO = CS_W + MODE_W;
  localparam int EDGE_B = ACT_LO + 2 * NCH;

  logic [CS_W-1:0]   cs_q;
  logic [MODE_W-1:0] mode_q;
  act_e              act_q [NCH];
  logic              edge_q;
  logic [CNT_W-1:0]  cmp_q [NCH];
  logic [NFLAG-1:0]  flags_q, flag_set;

  logic              ctrl_wr, restart, cnt_wr, capt_wr, flag_wr;
  logic [NFLAG-1:0]  flag_wmask;
  logic              tick, tick_eff, ovf_evt, capt_evt;
  logic [CNT_W-1:0]  cnt, capt;
  logic [NCH-1:0]    match_evt;
  logic [CTRL_W-1:0] ctrl_view;

  assign ctrl_wr    = reg_we && (reg_addr == A_CTRL);
  assign cnt_wr     = reg_we && (reg_addr == A_CNT);
  assign capt_wr    = reg_we && (reg_addr == A_CAPT);
  assign flag_wr    = reg_we && (reg_addr == A_FLAG);
  assign flag_wmask = reg_wdata[NFLAG-1:0];
  assign restart    = ctrl_wr &&
                      ((reg_wdata[CS_W-1:0] != cs_q) ||
                       (reg_wdata[CS_W +: MODE_W] != mode_q));
  assign tick_eff   = tick && !restart && !cnt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= '0;
      mode_q <= '0;
      edge_q <= 1'b0;
    end else if (ctrl_wr) begin
      cs_q   <= reg_wdata[CS_W-1:0];
      mode_q <= reg_wdata[CS_W +: MODE_W];
      edge_q <= reg_wdata[EDGE_B];
    end
  end

  cct_presc u_presc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cs(cs_q), .tick(tick)
  );

  cct_count u_count (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load(cnt_wr),
    .load_val(reg_wdata), .tick(tick_eff), .mode(mode_q),
    .top_a(cmp_q[0]), .top_i(capt), .cnt(cnt), .ovf_evt(ovf_evt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[c] <= ACT_OFF;
        cmp_q[c] <= '0;
      end else begin
        if (ctrl_wr) act_q[c] <= act_e'(reg_wdata[ACT_LO + 2*c +: 2]);
        if (reg_we && (reg_addr == A_CMPA + 3'(c))) cmp_q[c] <= reg_wdata;
      end
    end

    cct_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick_eff), .cnt(cnt),
      .cmp(cmp_q[c]), .act(act_q[c]), .ovf_evt(ovf_evt),
      .pwm(is_pwm(mode_q)), .match_evt(match_evt[c]), .pin(cmp_pin[c])
    );

    assign ctrl_view[ACT_LO + 2*c +: 2] = act_q[c];
  end

  assign ctrl_view[CS_W-1:0]      = cs_q;
  assign ctrl_view[CS_W +: MODE_W] = mode_q;
  assign ctrl_view[EDGE_B]        = edge_q;

  cct_capt u_capt (
    .clk(clk), .rst_n(rst_n), .pin_in(cap_in), .rise_sel(edge_q),
    .block(mode_q == MODE_PC_I), .cnt(cnt), .load(capt_wr),
    .load_val(reg_wdata), .capt(capt), .capt_evt(capt_evt)
  );

  // flag bit order: overflow, compare channels, capture
  assign flag_set = {capt_evt, match_evt, ovf_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= (flags_q & ~(flag_wr ? flag_wmask : '0)) | flag_set;
  end

  assign ovf_flag  = flags_q[0];
  assign cmp_flag  = flags_q[NCH:1];
  assign capt_flag = flags_q[NFLAG-1];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'(ctrl_view);
      A_CMPA:  reg_rdata = cmp_q[0];
      A_CMPB:  reg_rdata = cmp_q[1];
      A_CAPT:  reg_rdata = capt;
      A_FLAG:  reg_rdata = CNT_W'(flags_q);
      A_CNT:   reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker
  import cct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_eff,
  input logic              restart,
  input logic              cnt_wr,
  input logic [CS_W-1:0]   cs,
  input logic [MODE_W-1:0] mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp_a,
  input logic              ovf_evt,
  input logic              capt_evt,
  input logic [NFLAG-1:0]  flags,
  input logic              flag_wr,
  input logic [NFLAG-1:0]  flag_wmask
);
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == '0 && !restart && !cnt_wr) |=> $stable(cnt));

  a_r4_ctc_return: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && mode == MODE_CTC && cnt == cmp_a) |=> (cnt == '0));

  a_r9_capt_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PC_I) |-> !capt_evt);

  a_r10_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]);

  a_r10_capt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    capt_evt |=> flags[NFLAG-1]);

  a_r10_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(flag_wr && flag_wmask[0])) |=> flags[0]);

  a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

bind cap_cmp_timer cct_checker chk_i (
  .clk(clk), .rst_n(rst_n), .tick_eff(tick_eff), .restart(restart),
  .cnt_wr(cnt_wr), .cs(cs_q), .mode(mode_q), .cnt(cnt), .cmp_a(cmp_q[0]),
  .ovf_evt(ovf_evt), .capt_evt(capt_evt), .flags(flags_q),
  .flag_wr(flag_wr), .flag_wmask(flag_wmask)
);

// File: tb/cap_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cap_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        cap_in = 1'b0;
  logic [1:0]  cmp_pin;
  logic        ovf_flag, capt_flag;
  logic [1:0]  cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cap_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .cmp_pin(cmp_pin), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .capt_flag(capt_flag)
  );

  function automatic logic [15:0] ctrl(input int cs, input int mode,
                                       input int aa, input int ab, input int edg);
    return 16'((edg << 10) | (ab << 8) | (aa << 6) | (mode << 3) | cs);
  endfunction

  // expected count k clocks after a restart with clock select cs
  function automatic int exp_presc(input int k, input int cs);
    return k / (1 << (cs - 1));
  endfunction

  // expected count k ticks after restart in clear-on-compare mode
  function automatic int exp_ctc(input int k, input int top);
    return k % (top + 1);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halt_clear();
    wr(0, ctrl(0, 0, 0, 0, 0));
    wr(4, 16'hF);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, c, cs, k, top, p0;
    void'($urandom(32'd12345));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk(v, 0, $sformatf("R1 reg %0d", a));
    end
    chk(int'({cmp_pin, cmp_flag, ovf_flag, capt_flag}), 0, "R1 outputs");

    // R2 stopped counter holds
    rd(5, c);
    cyc(10);
    rd(5, v);
    chk(v, c, "R2 stopped");

    // R2 random prescale
    for (int i = 0; i < 8; i++) begin
      cs = 1 + int'($urandom % 4);
      k  = int'($urandom % 40);
      wr(0, ctrl(0, 0, 0, 0, 0));
      wr(0, ctrl(cs, 0, 0, 0, 0));
      cyc(k);
      rd(5, v);
      chk(v, exp_presc(k, cs), $sformatf("R2 cs=%0d k=%0d", cs, k));
    end

    // R11 edge-only change keeps count; clock-select change restarts
    wr(0, ctrl(0, 0, 0, 0, 0));
    wr(0, ctrl(1, 0, 0, 0, 0));
    cyc(20);
    wr(0, ctrl(1, 0, 0, 0, 1));
    rd(5, v);
    chk(v, 21, "R11 no restart");
    wr(0, ctrl(2, 0, 0, 0, 1));
    rd(5, v);
    chk(v, 0, "R11 restart");

    // R3 wrap and overflow
    halt_clear();
    wr(0, ctrl(1, 0, 0, 0, 0));
    wr(5, 16'hFFFE);
    cyc(1);
    rd(5, v);
    chk(v, 16'hFFFF, "R3 count max");
    chk(int'(ovf_flag), 0, "R3 no flag yet");
    cyc(1);
    rd(5, v);
    chk(v, 0, "R3 wrap");
    chk(int'(ovf_flag), 1, "R3 ovf flag");

    // R10 write 0 keeps, write 1 clears
    wr(4, 0);
    chk(int'(ovf_flag), 1, "R10 write0 keeps");
    wr(4, 1);
    chk(int'(ovf_flag), 0, "R10 write1 clears");

    // R4 random clear-on-compare
    for (int i = 0; i < 6; i++) begin
      top = 1 + int'($urandom % 9);
      k   = int'($urandom % 30);
      halt_clear();
      wr(1, top);
      wr(0, ctrl(1, 1, 0, 0, 0));
      cyc(k);
      rd(5, v);
      chk(v, exp_ctc(k, top), $sformatf("R4 top=%0d k=%0d", top, k));
    end

    // R4/R7 toggle on match in clear-on-compare
    halt_clear();
    wr(1, 5);
    wr(0, ctrl(1, 1, 1, 0, 0));
    p0 = int'(cmp_pin[0]);
    cyc(5);
    chk(int'(cmp_flag[0]), 0, "R4 flag before match");
    cyc(1);
    rd(5, v);
    chk(v, 0, "R4 return to zero");
    chk(int'(cmp_flag[0]), 1, "R4 match flag");
    chk(int'(cmp_pin[0]), 1 - p0, "R7 toggle first");
    cyc(6);
    chk(int'(cmp_pin[0]), p0, "R7 toggle second");

    // R10 hardware set beats clear; R7 disconnected pin low
    halt_clear();
    wr(1, 0);
    wr(2, 0);
    wr(0, ctrl(1, 1, 0, 0, 0));
    cyc(2);
    wr(4, 2);
    chk(int'(cmp_flag[0]), 1, "R10 set beats clear");
    chk(int'(cmp_pin[1]), 0, "R7 disconnected");

    // R5 fast PWM overflow then match actions
    halt_clear();
    wr(1, 1);
    wr(2, 3);
    wr(0, ctrl(1, 2, 3, 2, 0));
    wr(5, 16'hFFFE);
    cyc(2);
    chk(int'(cmp_pin), 2'b10, "R5 at overflow");
    cyc(2);
    chk(int'(cmp_pin), 2'b11, "R5 set on match A");
    cyc(2);
    chk(int'(cmp_pin), 2'b01, "R5 clear on match B");

    // R6 phase-correct up/down with TOP = compare A
    halt_clear();
    wr(1, 4);
    wr(0, ctrl(1, 3, 0, 0, 0));
    cyc(5);
    rd(5, v);
    chk(v, 3, "R6 after turn at top");
    cyc(3);
    rd(5, v);
    chk(v, 0, "R6 bottom");
    chk(int'(ovf_flag), 0, "R6 no ovf yet");
    cyc(1);
    rd(5, v);
    chk(v, 1, "R6 rising again");
    chk(int'(ovf_flag), 1, "R6 ovf at bottom");

    // R8 falling edge capture
    halt_clear();
    cap_in = 1'b1;
    cyc(4);
    wr(4, 16'hF);
    wr(0, ctrl(1, 0, 0, 0, 0));
    cyc(5);
    rd(5, c);
    cap_in = 1'b0;
    cyc(2);
    chk(int'(capt_flag), 0, "R8 flag latency");
    cyc(1);
    rd(3, v);
    chk(v, c + 2, "R8 falling capture value");
    chk(int'(capt_flag), 1, "R8 falling flag");

    // R8 rising edge after edge-only change
    wr(0, ctrl(1, 0, 0, 0, 1));
    wr(4, 16'h8);
    rd(5, c);
    cap_in = 1'b1;
    cyc(3);
    rd(3, v);
    chk(v, c + 2, "R8 rising capture value");
    chk(int'(capt_flag), 1, "R8 rising flag");
    wr(4, 16'h8);
    rd(3, p0);
    cap_in = 1'b0;
    cyc(4);
    rd(3, v);
    chk(v, p0, "R8 wrong polarity value");
    chk(int'(capt_flag), 0, "R8 wrong polarity flag");

    // R9 capture ignored while capture register is TOP
    halt_clear();
    wr(3, 100);
    wr(0, ctrl(1, 4, 0, 0, 1));
    cyc(2);
    cap_in = 1'b1;
    cyc(4);
    rd(3, v);
    chk(v, 100, "R9 capture reg kept");
    chk(int'(capt_flag), 0, "R9 no capture flag");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule